// File: doc/BRIEF.md
# Data-Operation Bus Cycle Sequencer

This block drives the memory-side control of a processor core while an ALU data instruction executes. When the execute stage pulses `start` it supplies four things: the instruction's flags, the current fetch base, the ALU result and the register that may hold a shift amount. The block then issues one to four bus cycles. For each cycle it gives the address, the transfer size, the direction, and whether the cycle asks for memory, is sequential and fetches an opcode.

There are four cycle sequences. A plain operation is one prefetch cycle. An operation whose shift amount comes from a register adds an internal cycle. In that cycle the low byte of the shift register goes into a holding latch and no memory is requested. An operation that writes the PC empties the pipeline. It then refetches from the ALU result and the next instruction after it, and holds off exceptions until the refill is done. The fourth sequence is a register shift combined with a PC write, which is only legal at the 4-byte width. Compare and test instructions write no result, so a PC destination flag on them starts no refill.

The first cycle of an operation is the cycle in which `start` is high, and its outputs come straight from the inputs. The block registers the operands and width at that point, and any later cycles use those registered copies.

Top module: `dop_bus_seq`

## Requirements
- R1: With `reg_shift`=0 and no effective PC write, the operation lasts one cycle, the cycle in which `start` is high. In it `addr`=pc+2L, where L is 4 when `wide`=1 and 2 otherwise. The other outputs are `mem_req`=1, `seq`=1, `fetch_op`=1 and `wr`=0. `size` is 2 when wide and 1 when narrow, and it keeps that value for every cycle of an operation. In the following cycle `busy`=0.
- R2: With `reg_shift`=1 the first cycle has `addr`=pc+2L, `mem_req`=0, `seq`=0, `fetch_op`=1 and `shift_load`=1. From the next cycle on, `shift_amt` equals the low 8 bits of `shift_src` as sampled in that first cycle.
- R3: A register-shift operation with no PC write has a second, internal cycle. In it `addr`=pc+3L, `mem_req`=1, `seq`=1 and `fetch_op`=0. The operation then ends.
- R4: A PC-writing operation without a register shift takes three cycles. Cycle 1 has pc+2L with `mem_req`=1, `seq`=0 and `fetch_op`=1. Cycle 2 has the ALU result with `flush`=1. Cycle 3 has ALU result+L. Cycles 2 and 3 have `mem_req`=`seq`=`fetch_op`=1.
- R5: `lockout` is 1 in every cycle of an operation with an effective PC write, and 0 in all other cycles.
- R6: A register shift with a PC write at `wide`=1 takes four cycles. Cycle 1 is pc+8 (as in R2). Cycle 2 is pc+12 with `mem_req`=1, `seq`=0 and `fetch_op`=0. Cycle 3 is the ALU result with `flush`=1. Cycle 4 is the ALU result+4.
- R7: With `no_write`=1 (compare or test), `dest_pc` has no effect. There is no refill, no `flush` and no `lockout`.
- R8: A register shift with an effective PC write at `wide`=0 raises `err` in its single cycle and otherwise behaves exactly as R1, with no shift load and no lockout.
- R9: `start` and all operand inputs are ignored while `busy`=1. An operation already running keeps its own addresses and flags to the end.
- R10: During and right after reset, `busy`, `mem_req`, `flush`, `lockout`, `shift_load`, `err` and `size` are 0, `addr` is 0 and `shift_amt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation; its cycle is the first bus cycle |
| reg_shift | input | 1 | Shift amount comes from a register |
| dest_pc | input | 1 | Result is written to the PC |
| no_write | input | 1 | Compare/test: no result written |
| wide | input | 1 | 1 = 4-byte instructions, 0 = 2-byte |
| pc | input | AW | Current fetch base address |
| alu_res | input | AW | ALU result (new PC for a PC write) |
| shift_src | input | SW | Register holding the shift amount |
| addr | output | AW | Bus address of this cycle |
| size | output | 2 | Transfer size code: 2 = word, 1 = halfword, 0 = idle |
| wr | output | 1 | Write strobe, always 0 (reads only) |
| mem_req | output | 1 | Memory request for the following cycle |
| seq | output | 1 | Following access is sequential |
| fetch_op | output | 1 | This cycle fetches an opcode |
| shift_load | output | 1 | Shift holding latch loads at the end of this cycle |
| shift_amt | output | 8 | Shift holding latch contents |
| flush | output | 1 | Pipeline invalidated; fetch from ALU result |
| lockout | output | 1 | Exceptions held off |
| err | output | 1 | Illegal shift-plus-PC combination in narrow state |
| busy | output | 1 | A multi-cycle operation is in its second or later cycle |

## Verification
The narrow-width register-shift-plus-PC combination is the hardest case to reach. It only arises when three flags line up against a fourth (`no_write` low), and it has to fall back to the one-cycle sequence and not the four-cycle one. The bench sweeps every combination of the four flags at both widths, with operands near the top of the address space to exercise wraparound. A start request arriving in the middle of a refill is also hard to bring about. To cover it, the bench re-raises `start` with inverted flags and altered operands in every cycle after the first. It then checks that the running sequence and the idle cycle that follows are unchanged.

// File: rtl/dop_pkg.sv
package dop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_INT,
        ST_SPC2,
        ST_REFILL0,
        ST_REFILL1
    } dop_state_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_NORM,
        CK_SHIFT1,
        CK_SHIFT_INT,
        CK_PC1,
        CK_SPC2,
        CK_ALU,
        CK_ALU_L
    } cyc_kind_e;

    typedef struct packed {
        logic req;
        logic seq;
        logic fop;
        logic lock;
        logic flush;
        logic sload;
    } bus_ctl_t;

    localparam logic [1:0] SIZE_WORD = 2'd2;
    localparam logic [1:0] SIZE_HALF = 2'd1;
    localparam logic [1:0] SIZE_NONE = 2'd0;

    function automatic logic [1:0] size_code(input logic wide);
        return wide ? SIZE_WORD : SIZE_HALF;
    endfunction

    function automatic cyc_kind_e state_kind(input dop_state_e st);
        case (st)
            ST_SHIFT_INT: return CK_SHIFT_INT;
            ST_SPC2:      return CK_SPC2;
            ST_REFILL0:   return CK_ALU;
            ST_REFILL1:   return CK_ALU_L;
            default:      return CK_NONE;
        endcase
    endfunction

    function automatic bus_ctl_t ctl_of(input cyc_kind_e k, input logic want_pc);
        bus_ctl_t c;
        c = '0;
        case (k)
            CK_NORM:      begin c.req = 1'b1; c.seq = 1'b1; c.fop = 1'b1; end
            CK_SHIFT1:    begin c.fop = 1'b1; c.sload = 1'b1; end
            CK_SHIFT_INT: begin c.req = 1'b1; c.seq = 1'b1; end
            CK_PC1:       begin c.req = 1'b1; c.fop = 1'b1; end
            CK_SPC2:      begin c.req = 1'b1; end
            CK_ALU:       begin c.req = 1'b1; c.seq = 1'b1; c.fop = 1'b1; c.flush = 1'b1; end
            CK_ALU_L:     begin c.req = 1'b1; c.seq = 1'b1; c.fop = 1'b1; end
            default:      c = '0;
        endcase
        c.lock = want_pc && (k != CK_NONE);
        return c;
    endfunction

endpackage

// File: rtl/dop_decode.sv
module dop_decode
    import dop_pkg::*;
(
    input  logic      reg_shift,
    input  logic      dest_pc,
    input  logic      no_write,
    input  logic      wide,
    output logic      want_pc,
    output logic      illegal,
    output cyc_kind_e first_kind
);
    logic pc_eff;

    always_comb begin
        pc_eff  = dest_pc && !no_write;
        illegal = pc_eff && reg_shift && !wide;
        want_pc = pc_eff && !illegal;
        if (illegal)
            first_kind = CK_NORM;
        else if (reg_shift)
            first_kind = CK_SHIFT1;
        else if (pc_eff)
            first_kind = CK_PC1;
        else
            first_kind = CK_NORM;
    end
endmodule

// File: rtl/dop_step_fsm.sv
module dop_step_fsm
    import dop_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_kind_e     kind,
    input  logic          want_pc_cur,
    input  logic          capture,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] alu_in,
    input  logic          wide_in,
    input  logic          want_pc_in,
    output dop_state_e    state,
    output logic [AW-1:0] ctx_pc,
    output logic [AW-1:0] ctx_alu,
    output logic          ctx_wide,
    output logic          ctx_want_pc
);
    dop_state_e state_nx;

    always_comb begin
        case (kind)
            CK_SHIFT1: state_nx = want_pc_cur ? ST_SPC2 : ST_SHIFT_INT;
            CK_PC1:    state_nx = ST_REFILL0;
            CK_SPC2:   state_nx = ST_REFILL0;
            CK_ALU:    state_nx = ST_REFILL1;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ctx_pc      <= '0;
            ctx_alu     <= '0;
            ctx_wide    <= 1'b0;
            ctx_want_pc <= 1'b0;
        end else begin
            state <= state_nx;
            if (capture) begin
                ctx_pc      <= pc_in;
                ctx_alu     <= alu_in;
                ctx_wide    <= wide_in;
                ctx_want_pc <= want_pc_in;
            end
        end
    end
endmodule

// File: rtl/dop_addr_gen.sv
module dop_addr_gen
    import dop_pkg::*;
#(
    parameter int AW = 32
) (
    input  cyc_kind_e     kind,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] alu,
    input  logic          wide,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_W = AW'(4);
    localparam logic [AW-1:0] STEP_N = AW'(2);

    logic [AW-1:0] step;
    logic [AW-1:0] two_step;
    logic [AW-1:0] three_step;

    always_comb begin
        step       = wide ? STEP_W : STEP_N;
        two_step   = step << 1;
        three_step = two_step + step;
        case (kind)
            CK_NORM, CK_SHIFT1, CK_PC1: addr = base + two_step;
            CK_SHIFT_INT, CK_SPC2:      addr = base + three_step;
            CK_ALU:                     addr = alu;
            CK_ALU_L:                   addr = alu + step;
            default:                    addr = '0;
        endcase
    end
endmodule

// File: rtl/dop_shift_latch.sv
module dop_shift_latch #(
    parameter int SW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] src,
    output logic [LW-1:0] amt
);
    always_ff @(posedge clk) begin
        if (rst)
            amt <= '0;
        else if (load)
            amt <= src[LW-1:0];
    end
endmodule

// File: rtl/dop_bus_seq.sv
module dop_bus_seq
    import dop_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          reg_shift,
    input  logic          dest_pc,
    input  logic          no_write,
    input  logic          wide,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] alu_res,
    input  logic [SW-1:0] shift_src,
    output logic [AW-1:0] addr,
    output logic [1:0]    size,
    output logic          wr,
    output logic          mem_req,
    output logic          seq,
    output logic          fetch_op,
    output logic          shift_load,
    output logic [LW-1:0] shift_amt,
    output logic          flush,
    output logic          lockout,
    output logic          err,
    output logic          busy
);
    dop_state_e    state;
    cyc_kind_e     first_kind;
    cyc_kind_e     kind;
    logic          want_pc_in;
    logic          illegal;
    logic          idle;
    logic          capture;
    logic          wide_cur;
    logic          want_pc_cur;
    logic [AW-1:0] ctx_pc;
    logic [AW-1:0] ctx_alu;
    logic          ctx_wide;
    logic          ctx_want_pc;
    logic [AW-1:0] base_cur;
    logic [AW-1:0] alu_cur;
    bus_ctl_t      ctl;

    dop_decode u_dec (
        .reg_shift  (reg_shift),
        .dest_pc    (dest_pc),
        .no_write   (no_write),
        .wide       (wide),
        .want_pc    (want_pc_in),
        .illegal    (illegal),
        .first_kind (first_kind)
    );

    always_comb begin
        idle        = (state == ST_IDLE);
        capture     = idle && start;
        kind        = idle ? (start ? first_kind : CK_NONE) : state_kind(state);
        wide_cur    = idle ? wide : ctx_wide;
        want_pc_cur = idle ? want_pc_in : ctx_want_pc;
        base_cur    = idle ? pc : ctx_pc;
        alu_cur     = idle ? alu_res : ctx_alu;
        ctl         = ctl_of(kind, want_pc_cur);
    end

    dop_step_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .want_pc_cur (want_pc_cur),
        .capture     (capture),
        .pc_in       (pc),
        .alu_in      (alu_res),
        .wide_in     (wide),
        .want_pc_in  (want_pc_in),
        .state       (state),
        .ctx_pc      (ctx_pc),
        .ctx_alu     (ctx_alu),
        .ctx_wide    (ctx_wide),
        .ctx_want_pc (ctx_want_pc)
    );

    dop_addr_gen #(.AW(AW)) u_addr (
        .kind (kind),
        .base (base_cur),
        .alu  (alu_cur),
        .wide (wide_cur),
        .addr (addr)
    );

    dop_shift_latch #(.SW(SW), .LW(LW)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.sload),
        .src  (shift_src),
        .amt  (shift_amt)
    );

    always_comb begin
        size       = (kind == CK_NONE) ? SIZE_NONE : size_code(wide_cur);
        wr         = 1'b0;
        mem_req    = ctl.req;
        seq        = ctl.seq;
        fetch_op   = ctl.fop;
        shift_load = ctl.sload;
        flush      = ctl.flush;
        lockout    = ctl.lock;
        err        = capture && illegal;
        busy       = !idle;
    end
endmodule

// File: rtl/dop_bus_seq_chk.sv
module dop_bus_seq_chk #(
    parameter int AW = 32,
    parameter int SW = 32,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [SW-1:0] shift_src,
    input logic [1:0]    size,
    input logic          mem_req,
    input logic          seq,
    input logic          fetch_op,
    input logic          shift_load,
    input logic [LW-1:0] shift_amt,
    input logic          flush,
    input logic          lockout,
    input logic          err,
    input logic          busy,
    input logic [AW-1:0] addr
);
    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |-> size == $past(size)); // R1
    AST_LOAD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        shift_load |-> (!mem_req && !seq && fetch_op)); // R2
    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        shift_load |=> shift_amt == $past(shift_src[LW-1:0])); // R2
    AST_INTERNAL_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        shift_load |=> (!fetch_op && mem_req && busy)); // R3
    AST_REFILL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (mem_req && seq && fetch_op && lockout && busy)); // R4
    AST_FLUSH_LOCKED: assert property (@(posedge clk) disable iff (rst)
        flush |-> lockout); // R5
    AST_ERR_PLAIN: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !lockout && !shift_load && mem_req)); // R8
    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
        err |=> !busy); // R8
endmodule

bind dop_bus_seq dop_bus_seq_chk #(.AW(AW), .SW(SW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_src  (shift_src),
    .size       (size),
    .mem_req    (mem_req),
    .seq        (seq),
    .fetch_op   (fetch_op),
    .shift_load (shift_load),
    .shift_amt  (shift_amt),
    .flush      (flush),
    .lockout    (lockout),
    .err        (err),
    .busy       (busy),
    .addr       (addr)
);

// File: tb/dop_bus_seq_test.sv
module dop_bus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        reg_shift = 1'b0;
    logic        dest_pc = 1'b0;
    logic        no_write = 1'b0;
    logic        wide = 1'b0;
    logic [31:0] pc = '0;
    logic [31:0] alu_res = '0;
    logic [31:0] shift_src = '0;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr, mem_req, seq, fetch_op, shift_load, flush, lockout, err, busy;
    logic [7:0]  shift_amt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dop_bus_seq uut (
        .clk(clk), .rst(rst), .start(start), .reg_shift(reg_shift), .dest_pc(dest_pc),
        .no_write(no_write), .wide(wide), .pc(pc), .alu_res(alu_res), .shift_src(shift_src),
        .addr(addr), .size(size), .wr(wr), .mem_req(mem_req), .seq(seq), .fetch_op(fetch_op),
        .shift_load(shift_load), .shift_amt(shift_amt), .flush(flush), .lockout(lockout),
        .err(err), .busy(busy)
    );

    function automatic logic [42:0] act_vec();
        return {addr, size, wr, mem_req, seq, fetch_op, lockout, flush, shift_load, err, busy};
    endfunction

    // mode: 0 plain, 1 register shift, 2 PC write, 3 shift + PC write
    function automatic logic [42:0] exp_vec(input int mode, input int i, input logic wd,
                                            input logic ill, input logic lk,
                                            input logic [31:0] p, input logic [31:0] a);
        logic [31:0] l, ad;
        logic rq, sq, fo, fl, sl;
        l = wd ? 32'd4 : 32'd2;
        ad = '0; rq = 0; sq = 0; fo = 0; fl = 0; sl = 0;
        if (i == 1) begin
            ad = p + 2 * l; fo = 1;
            if (mode == 0) begin rq = 1; sq = 1; end
            else if (mode == 2) rq = 1;
            else sl = 1;
        end else if (i == 2 && (mode == 1 || mode == 3)) begin
            ad = p + 3 * l; rq = 1; sq = (mode == 1);
        end else if ((i == 2 && mode == 2) || (i == 3 && mode == 3)) begin
            ad = a; rq = 1; sq = 1; fo = 1; fl = 1;
        end else begin
            ad = a + l; rq = 1; sq = 1; fo = 1;
        end
        return {ad, wd ? 2'd2 : 2'd1, 1'b0, rq, sq, fo, lk, fl, sl, ill && i == 1, i > 1};
    endfunction

    task automatic check(input string req, input logic [42:0] act, input logic [42:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pcs [3];
        logic [31:0] alus [3];
        pcs[0] = 32'h0000_1000; alus[0] = 32'h0000_8000;
        pcs[1] = 32'hFFFF_FFF8; alus[1] = 32'hFFFF_FFFE;
        pcs[2] = 32'h1234_5670; alus[2] = 32'h0000_0000;

        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        check("R10 reset", {act_vec(), shift_amt}, 51'd0);
        rst = 1'b0;
        @(negedge clk); #2;
        check("R10 after reset", {act_vec(), shift_amt}, 51'd0);

        for (int v = 0; v < 3; v++) begin
            for (int f = 0; f < 16; f++) begin
                logic rs, dp, nw, wd, wantpc, ill, lk;
                int mode, n;
                string tag;
                rs = f[0]; dp = f[1]; nw = f[2]; wd = f[3];
                wantpc = dp && !nw;
                ill = wantpc && rs && !wd;
                lk = wantpc && !ill;
                if (ill) mode = 0;
                else if (rs && wantpc) mode = 3;
                else if (rs) mode = 1;
                else if (wantpc) mode = 2;
                else mode = 0;
                n = (mode == 0) ? 1 : (mode == 1) ? 2 : (mode == 2) ? 3 : 4;
                if (ill) tag = "R8";
                else if (dp && nw) tag = "R7";
                else if (mode == 0) tag = "R1";
                else if (mode == 1) tag = "R2/R3";
                else if (mode == 2) tag = "R4/R5";
                else tag = "R6/R5";
                for (int i = 1; i <= n; i++) begin
                    @(negedge clk);
                    if (i == 1) begin
                        start = 1; reg_shift = rs; dest_pc = dp; no_write = nw; wide = wd;
                        pc = pcs[v]; alu_res = alus[v]; shift_src = 32'hA5A5_A500 + 32'(f * 7 + v);
                    end else begin
                        // R9: disturb every input while the operation runs
                        start = 1; reg_shift = !rs; dest_pc = !dp; no_write = !nw; wide = !wd;
                        pc = ~pcs[v]; alu_res = ~alus[v]; shift_src = 32'h0;
                    end
                    #2;
                    check(tag, act_vec(), exp_vec(mode, i, wd, ill, lk, pcs[v], alus[v]));
                    if (i == 2 && (mode == 1 || mode == 3))
                        check("R2 latch", {35'd0, shift_amt},
                              {35'd0, 8'(32'hA5A5_A500 + 32'(f * 7 + v))});
                end
                @(negedge clk);
                start = 0; reg_shift = 0; dest_pc = 0; no_write = 0; wide = 0;
                #2;
                check("R9 idle after op", act_vec(), 43'd0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule